// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Shifter

This block sends a fixed-width identification word out on the open-drain serial data line of a two-wire memory interface. The word is sent in response to a card reset: when the card reset input is high on a rising edge of the serial clock, the block captures the word from its input port. From then on it presents one bit per serial clock pulse, least significant bit first. Each bit changes only after a falling edge of the serial clock, so the host can sample it on the following rising edge.

While a sequence is in progress, the block owns the data line. It holds the command slave in its idle state and ignores that slave's request to pull the line low. After the last bit has been clocked out, it releases the line and hands control back. Each time the card reset input goes high, the block also sends a single-cycle pulse that revokes every verified password and authentication elsewhere in the device.

All inputs are synchronous to the system clock `clk`, which runs much faster than the serial clock. The block finds the serial clock edges by comparing each sample of the serial clock with the previous one.

Top module: `atr_shifter`

## Requirements
- R1: After system reset, `busy` and `cmdHold` are 0 and `dataPullLow` equals `cmdPullLow`, for both values of `cmdPullLow`.
- R2: A rising edge of `serClk` while `cardReset` is 1 starts a sequence. `busy` is 1 from the next `clk` cycle. The value of `atrWord` in that cycle is captured, and later changes of `atrWord` do not affect the bits sent.
- R3: Between the starting pulse and its falling edge, the data line is released (`dataPullLow` = 0). After that falling edge, bit 0 of the captured word is presented. After the k-th following falling edge, bit k is presented. A 0 bit is sent as `dataPullLow` = 1 and a 1 bit as `dataPullLow` = 0.
- R4: While a sequence runs, `dataPullLow` changes only in the cycle after a `serClk` falling edge or after a restarting pulse. It stays stable across the rising edge and the high phase of `serClk`.
- R5: The falling edge of the 32nd `serClk` pulse after the starting pulse ends the sequence. `busy` drops in the next cycle and `dataPullLow` follows `cmdPullLow` again.
- R6: A `serClk` rising edge with `cardReset` high in the middle of a sequence restarts it. It captures `atrWord` anew, releases the data line, keeps `busy` high, and sends from bit 0 after that pulse falls.
- R7: `privClear` is a one-cycle pulse in the cycle after each 0-to-1 change of `cardReset`, whether or not `serClk` moves. It is 0 at all other times.
- R8: While `busy` is 1, `cmdHold` is 1 and `cmdPullLow` has no effect on `dataPullLow`. While `busy` is 0, `cmdHold` is 0.
- R9: `cardReset` going high and low again while `serClk` stays low starts no sequence. `serClk` pulses with `cardReset` low while idle also start no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| serClk | input | 1 | Serial clock, sampled on `clk` |
| cardReset | input | 1 | Card reset request, sampled on `clk` |
| atrWord | input | WORD_W | Identification word to send, captured at the start of a sequence |
| cmdPullLow | input | 1 | Command slave's request to pull the data line low |
| dataPullLow | output | 1 | Drive low on the open-drain data line (1 = pull low, 0 = released) |
| busy | output | 1 | A sequence is in progress |
| cmdHold | output | 1 | Holds the command slave idle and stops its decoding |
| privClear | output | 1 | One-cycle pulse that revokes password and authentication privileges |

## Verification
Two functions can fall in the same cycle. A restarting reset pulse can arrive while a bit is being presented, so capture and restart compete with the running shift. The privilege-clearing pulse can also come out together with a sequence start or restart. The bench makes these happen by placing restarting pulses at random bit positions, and by raising `cardReset` in the same cycle as the `serClk` rising edge. It checks the data line against a bench model of bit index and captured word, before and after every serial clock edge. It also counts `privClear` pulses against the number of `cardReset` rises.

// File: rtl/atr_pkg.sv
package atr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_SHIFT = 2'd2
  } phase_t;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic loadWord;   // capture word, release line
    logic showFirst;  // begin driving bit 0
    logic stepBit;    // move to next bit
    logic endSeq;     // last bit done, release line
  } atr_strobe_t;

endpackage

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        cardReset,
  output atr_strobe_t strobe,
  output logic        busy,
  output logic        privClear
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             clkPrev;
  logic             resetPrev;
  logic             clkRise;
  logic             clkFall;
  logic             atLast;

  assign clkRise = serClk & ~clkPrev;
  assign clkFall = ~serClk & clkPrev;
  assign atLast  = (bitCnt == LAST_BIT);

  always_comb begin
    strobe           = '0;
    strobe.loadWord  = clkRise & cardReset;
    strobe.showFirst = clkFall && (phase == PH_ARMED);
    strobe.stepBit   = clkFall && (phase == PH_SHIFT) && !atLast;
    strobe.endSeq    = clkFall && (phase == PH_SHIFT) && atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      clkPrev   <= 1'b0;
      resetPrev <= 1'b0;
      privClear <= 1'b0;
    end else begin
      clkPrev   <= serClk;
      resetPrev <= cardReset;
      privClear <= cardReset & ~resetPrev;
      if (strobe.loadWord) begin
        phase  <= PH_ARMED;
        bitCnt <= '0;
      end else if (strobe.showFirst) begin
        phase <= PH_SHIFT;
      end else if (strobe.stepBit) begin
        bitCnt <= bitCnt + 1'b1;
      end else if (strobe.endSeq) begin
        phase <= PH_IDLE;
      end
    end
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/atr_datapath.sv
module atr_datapath
  import atr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  atr_strobe_t       strobe,
  input  logic [WORD_W-1:0] atrWord,
  output logic              atrPullLow
);

  logic [WORD_W-1:0] shiftReg;
  logic              drvOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      drvOn    <= 1'b0;
    end else if (strobe.loadWord) begin
      shiftReg <= atrWord;
      drvOn    <= 1'b0;
    end else if (strobe.showFirst) begin
      drvOn <= 1'b1;
    end else if (strobe.stepBit) begin
      shiftReg <= {1'b1, shiftReg[WORD_W-1:1]};
    end else if (strobe.endSeq) begin
      shiftReg <= '1;
      drvOn    <= 1'b0;
    end
  end

  // open drain: a zero bit pulls the line low
  assign atrPullLow = drvOn & ~shiftReg[0];

endmodule

// File: rtl/atr_sda_arb.sv
module atr_sda_arb (
  input  logic busy,
  input  logic atrPullLow,
  input  logic cmdPullLow,
  output logic dataPullLow,
  output logic cmdHold
);

  assign dataPullLow = busy ? atrPullLow : cmdPullLow;
  assign cmdHold     = busy;

endmodule

// File: rtl/atr_shifter.sv
module atr_shifter
  import atr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              cardReset,
  input  logic [WORD_W-1:0] atrWord,
  input  logic              cmdPullLow,
  output logic              dataPullLow,
  output logic              busy,
  output logic              cmdHold,
  output logic              privClear
);

  atr_strobe_t strobe;
  logic        atrPullLow;

  atr_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .cardReset (cardReset),
    .strobe    (strobe),
    .busy      (busy),
    .privClear (privClear)
  );

  atr_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .atrWord    (atrWord),
    .atrPullLow (atrPullLow)
  );

  atr_sda_arb u_arb (
    .busy        (busy),
    .atrPullLow  (atrPullLow),
    .cmdPullLow  (cmdPullLow),
    .dataPullLow (dataPullLow),
    .cmdHold     (cmdHold)
  );

endmodule

// File: rtl/atr_shifter_chk.sv
module atr_shifter_chk (
  input logic clk,
  input logic rstN,
  input logic serClk,
  input logic cardReset,
  input logic busy,
  input logic cmdHold,
  input logic dataPullLow,
  input logic privClear
);

  logic clkD;
  logic resetD;
  logic fallNow;
  logic restartNow;
  logic resetRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkD   <= 1'b0;
      resetD <= 1'b0;
    end else begin
      clkD   <= serClk;
      resetD <= cardReset;
    end
  end

  assign fallNow    = clkD & ~serClk;
  assign restartNow = serClk & ~clkD & cardReset;
  assign resetRise  = cardReset & ~resetD;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(restartNow)) |-> busy);

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && busy && $past(busy) && !$stable(dataPullLow))
      |-> ($past(fallNow) || $past(restartNow)));

  p_end_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(busy)) |-> $past(fallNow));

  p_restart_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(restartNow) && $past(busy)) |-> (busy && !dataPullLow));

  p_priv_after_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(resetRise)) |-> privClear);

  p_priv_only_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && privClear) |-> $past(resetRise));

  p_hold_while_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> cmdHold);

endmodule

bind atr_shifter atr_shifter_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .serClk      (serClk),
  .cardReset   (cardReset),
  .busy        (busy),
  .cmdHold     (cmdHold),
  .dataPullLow (dataPullLow),
  .privClear   (privClear)
);

// File: tb/atr_shifter_bench.sv
module atr_shifter_bench;

  localparam int W    = 32;
  localparam int HALF = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         serClk = 1'b0;
  logic         cardReset = 1'b0;
  logic [W-1:0] atrWord = '0;
  logic         cmdPullLow = 1'b0;
  logic         dataPullLow;
  logic         busy;
  logic         cmdHold;
  logic         privClear;

  int checkCnt = 0;
  int failCnt  = 0;
  int privCnt  = 0;
  bit done     = 0;

  // bench model
  bit           expBusy  = 0;
  bit           expArmed = 0;
  int           expIdx   = 0;
  logic [W-1:0] expWord  = '0;
  int           expPriv  = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rstN && privClear) privCnt <= privCnt + 1;

  atr_shifter #(.WORD_W(W)) u_atr_shifter (
    .clk(clk), .rstN(rstN), .serClk(serClk), .cardReset(cardReset),
    .atrWord(atrWord), .cmdPullLow(cmdPullLow), .dataPullLow(dataPullLow),
    .busy(busy), .cmdHold(cmdHold), .privClear(privClear)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit expLine();
    if (expBusy) return !expArmed && !expWord[expIdx];
    return cmdPullLow;
  endfunction

  task automatic sample(input string req);
    check(busy == expBusy, req, "busy", 32'(busy), 32'(expBusy));
    check(cmdHold == expBusy, "R8", "cmdHold", 32'(cmdHold), 32'(expBusy));
    check(dataPullLow == expLine(), req, "dataPullLow",
          32'(dataPullLow), 32'(expLine()));
  endtask

  // one serial clock pulse; withRst holds cardReset high across the rise
  task automatic pulse(input bit withRst, input bit scrambleWord);
    @(negedge clk);
    cmdPullLow = 1'($urandom);
    cardReset  = withRst;
    serClk     = 1'b1;
    if (withRst) begin
      expArmed = 1; expBusy = 1; expIdx = 0; expWord = atrWord; expPriv++;
    end
    repeat (HALF) @(negedge clk);
    sample(withRst ? "R2/R6" : "R4");
    if (scrambleWord) atrWord = $urandom;  // R2: later changes are ignored
    cmdPullLow = 1'($urandom);
    serClk     = 1'b0;
    cardReset  = 1'b0;
    if (expArmed) begin
      expArmed = 0; expIdx = 0;
    end else if (expBusy) begin
      if (expIdx == W - 1) expBusy = 0;
      else expIdx++;
    end
    repeat (HALF) @(negedge clk);
    sample(expBusy ? "R3/R8" : "R5");
    check(privCnt == expPriv, "R7", "privClear count", 32'(privCnt), 32'(expPriv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, both command drive values
    cmdPullLow = 1'b0; @(negedge clk); sample("R1");
    cmdPullLow = 1'b1; @(negedge clk); sample("R1");
    check(privCnt == 0, "R1", "privClear count", 32'(privCnt), 0);

    // R9 idle pulses without card reset
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b0);
    // R9 and R7: card reset toggles while serial clock stays low
    @(negedge clk); cardReset = 1'b1; expPriv++;
    repeat (4) @(negedge clk); sample("R9");
    cardReset = 1'b0;
    repeat (2) @(negedge clk); sample("R9");
    check(privCnt == expPriv, "R7", "privClear count", 32'(privCnt), 32'(expPriv));

    // R3/R5 full sequence with a fixed word, word scrambled after capture
    atrWord = 32'h3C5A_96E1;
    pulse(1'b1, 1'b1);
    for (int i = 0; i < W; i++) pulse(1'b0, 1'b1);
    check(busy == 1'b0, "R5", "busy after last bit", 32'(busy), 0);

    // R6 restart in the middle at bit 10
    atrWord = 32'hFFFF_0000;
    pulse(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) pulse(1'b0, 1'b0);
    atrWord = 32'h0F0F_5A5A;
    pulse(1'b1, 1'b0);
    for (int i = 0; i < W; i++) pulse(1'b0, 1'b0);
    check(busy == 1'b0, "R6", "busy after restarted run", 32'(busy), 0);

    // R6 restart on the final bit
    atrWord = $urandom;
    pulse(1'b1, 1'b0);
    for (int i = 0; i < W - 1; i++) pulse(1'b0, 1'b0);
    atrWord = $urandom;
    pulse(1'b1, 1'b0);
    for (int i = 0; i < W; i++) pulse(1'b0, 1'b0);

    // constrained random runs with occasional restarts and idle pulses
    for (int s = 0; s < 25; s++) begin
      atrWord = $urandom;
      pulse(1'b1, 1'b1);
      for (int i = 0; i < W + 8; i++) begin
        if (!expBusy) break;
        pulse(($urandom % 20) == 0, 1'($urandom));
      end
      while (expBusy) pulse(1'b0, 1'b0);
      for (int i = 0; i < int'($urandom % 3); i++) pulse(1'b0, 1'b0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule